// File: doc/BRIEF.md
# Three-Slave Host Port Decoder

This block sits on the 8-bit I/O bus of a master processor and gives that master a mailbox-style view of three slave CPUs that share one board base address. Four active-low jumper inputs set the high nibble of that base. Each slave owns a window of four consecutive ports: the first is a status port when read and a control port when written. The second carries data in both directions. The third clears a slave flag, and the fourth is unused.

The decoder holds each slave's reset line and its master-message flag. It latches the byte the master hands to each slave and releases a slave that is stalled on a data-port access. The slave-side mailbox reports its hold, direction, alive and slave-message flags as plain level inputs, and it offers a byte while it is stalled on a write. Transfers follow a simple handshake. A slave byte is valid while that slave holds with its direction set to writing, and a master data read is the ready that consumes it. A master byte is accepted only while the slave holds with its direction set to reading. Otherwise the master write is dropped and no release is issued. A master data read with no byte offered returns 0xFF.

Reads are combinational from the address and `io_rd`. All state changes, release pulses and clear pulses are registered and appear one clock after the strobe edge. `io_rd` and `io_wr` are one-cycle strobes.

Top module: `mslv_host_port`

## Requirements
- R1: The window base is the inverse of `base_jmp_n`, placed in address bits 7..4. Slave i answers at base+4i+0, +1 and +2 (bits 3..2 select the slave, bits 1..0 the port). A slave index of 3, port offset 3, or any other high nibble is ignored: a write there changes no state, and a read there returns 0xFF. `io_rdata` is 0xFF whenever `io_rd` is low.
- R2: A status read returns bit0 = master message, bit1 = slave message, bit2 = alive (active low), bit3 = hold (active low), bit4 = direction (1 when the slave reads, 0 when it writes), bit5 = reset (active low), and bits 7..6 = 1.
- R3: On a control write, bit 4 sets that slave's reset (1) or clears it (0). Bit 1 = 1 sets the master-message flag, and bit 1 = 0 leaves the flag as it was. The other bits have no effect.
- R4: After `rst_n`, all three slaves are held in reset, with master message 0 and master-to-slave bytes 0.
- R5: A one-cycle pulse on `slv_mmsg_ack[i]` clears that slave's master-message flag. A control write that sets the flag in the same cycle takes precedence.
- R6: A data-port read of a slave that holds while writing returns `slv_wdata` for that slave and pulses `slv_release[i]` for one cycle on the next clock. In any other state the read returns 0xFF and produces no release.
- R7: A data-port write to a slave that holds while reading loads `m2s_data` for that slave and pulses `slv_release[i]` on the next clock. In any other state the write leaves `m2s_data` unchanged and produces no release.
- R8: A read of the flag port pulses `alive_clr[i]`, and a write of it pulses `smsg_clr[i]`, one clock after the strobe.
- R9: While a slave is in reset, its status shows hold, alive and slave message as inactive. Its master message and `m2s_data` are cleared, and reset wins over a simultaneous bit 1. `alive_clr[i]` and `smsg_clr[i]` stay high, and no release is issued.
- R10: Each slave's state changes only through accesses that decode to its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| base_jmp_n | input | 4 | Base jumpers, fitted = 0; inverse gives address bits 7..4 |
| io_addr | input | 8 | Master I/O address |
| io_rd | input | 1 | Master read strobe |
| io_wr | input | 1 | Master write strobe |
| io_wdata | input | 8 | Master write data |
| io_rdata | output | 8 | Master read data, 0xFF when not decoded |
| slv_hold | input | NSLV | Slave i stalled on a data-port access |
| slv_rd_dir | input | NSLV | 1 = slave stalled reading, 0 = writing |
| slv_alive | input | NSLV | Slave alive flag |
| slv_smsg | input | NSLV | Slave message flag |
| slv_mmsg_ack | input | NSLV | Slave clears its master-message flag |
| slv_wdata | input | 8*NSLV | Byte offered by each slave (slave i in bits 8i+7..8i) |
| slv_reset | output | NSLV | Reset to slave CPU i |
| slv_mmsg | output | NSLV | Master-message flag to slave i |
| slv_release | output | NSLV | One-cycle release of a stalled slave |
| m2s_data | output | 8*NSLV | Latched master byte for each slave |
| alive_clr | output | NSLV | Clear request for the slave alive flag |
| smsg_clr | output | NSLV | Clear request for the slave message flag |

## Verification
The bench sweeps every jumper code against every address, in several flag patterns and with the slaves both held and running. A swapped nibble, an off-by-one window or a decoded fourth port therefore shows up as a wrong byte where 0xFF was due. It aims at the handshake corners: a data access to a slave that is not stalled in the matching direction must neither release it nor disturb its latch. A decoder that ignores direction would release a writer on a master write. It also checks the priorities: reset against a simultaneous set of the master message, and a set against an ack. A design that kept the flag, or kept the pending byte across reset, would hand stale data to a freshly started slave. Control bits other than bits 4 and 1, and out-of-window writes carrying a reset code, are driven to prove they change nothing.

// File: rtl/mslv_pkg.sv
package mslv_pkg;
  // port offset inside a slave's four-port window
  typedef enum logic [1:0] {
    PORT_CTL  = 2'd0,
    PORT_DATA = 2'd1,
    PORT_FLAG = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  localparam logic [7:0] FLOAT_BYTE = 8'hFF;

  // control-byte bit positions
  localparam int CTL_RST_BIT  = 4;
  localparam int CTL_MMSG_BIT = 1;

  function automatic logic [7:0] pack_status(
    input logic mmsg, input logic smsg, input logic alive,
    input logic hold, input logic rd_dir, input logic in_rst);
    pack_status = {2'b11, ~in_rst, rd_dir,
                   ~(hold & ~in_rst), ~(alive & ~in_rst),
                   smsg & ~in_rst, mmsg};
  endfunction
endpackage

// File: rtl/mslv_addr_dec.sv
module mslv_addr_dec
  import mslv_pkg::*;
#(
  parameter int NSLV = 3
) (
  input  logic [3:0]      base_jmp_n,
  input  logic [7:0]      io_addr,
  input  logic            io_rd,
  input  logic            io_wr,
  output logic            hit,
  output logic [NSLV-1:0] ctl_rd,
  output logic [NSLV-1:0] ctl_wr,
  output logic [NSLV-1:0] dat_rd,
  output logic [NSLV-1:0] dat_wr,
  output logic [NSLV-1:0] flg_rd,
  output logic [NSLV-1:0] flg_wr
);
  logic       in_blk;
  logic [1:0] slot;
  port_e      port;

  assign in_blk = (io_addr[7:4] == ~base_jmp_n);
  assign slot   = io_addr[3:2];
  assign port   = port_e'(io_addr[1:0]);
  assign hit    = in_blk && (32'(slot) < NSLV) && (port != PORT_NONE);

  for (genvar g = 0; g < NSLV; g++) begin : g_sel
    logic mine;
    assign mine      = in_blk && (slot == 2'(g));
    assign ctl_rd[g] = mine && port == PORT_CTL  && io_rd;
    assign ctl_wr[g] = mine && port == PORT_CTL  && io_wr;
    assign dat_rd[g] = mine && port == PORT_DATA && io_rd;
    assign dat_wr[g] = mine && port == PORT_DATA && io_wr;
    assign flg_rd[g] = mine && port == PORT_FLAG && io_rd;
    assign flg_wr[g] = mine && port == PORT_FLAG && io_wr;
  end
endmodule

// File: rtl/mslv_slot.sv
module mslv_slot
  import mslv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       dat_rd,
  input  logic       dat_wr,
  input  logic       flg_rd,
  input  logic       flg_wr,
  input  logic [7:0] wdata,
  input  logic       hold,
  input  logic       rd_dir,
  input  logic       alive,
  input  logic       smsg,
  input  logic       mmsg_ack,
  input  logic [7:0] slv_byte,
  output logic       slv_reset,
  output logic       mmsg,
  output logic       release_o,
  output logic [7:0] m2s_data,
  output logic       alive_clr,
  output logic       smsg_clr,
  output logic [7:0] status,
  output logic [7:0] s2m_rdata
);
  logic       rst_q, mmsg_q, rel_q, aclr_q, sclr_q;
  logic [7:0] m2s_q;
  logic       rst_d, s2m_ok, m2s_ok;

  assign rst_d  = ctl_wr ? wdata[CTL_RST_BIT] : rst_q;
  assign s2m_ok = hold & ~rd_dir & ~rst_q;
  assign m2s_ok = hold &  rd_dir & ~rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b1;
      mmsg_q <= 1'b0;
      rel_q  <= 1'b0;
      aclr_q <= 1'b1;
      sclr_q <= 1'b1;
      m2s_q  <= '0;
    end else begin
      rst_q <= rst_d;
      if (rst_d)                             mmsg_q <= 1'b0;
      else if (ctl_wr && wdata[CTL_MMSG_BIT]) mmsg_q <= 1'b1;
      else if (mmsg_ack)                     mmsg_q <= 1'b0;
      if (rst_d)                 m2s_q <= '0;
      else if (dat_wr && m2s_ok) m2s_q <= wdata;
      rel_q  <= (dat_rd & s2m_ok) | (dat_wr & m2s_ok);
      aclr_q <= flg_rd | rst_d;
      sclr_q <= flg_wr | rst_d;
    end
  end

  assign slv_reset = rst_q;
  assign mmsg      = mmsg_q;
  assign release_o = rel_q;
  assign m2s_data  = m2s_q;
  assign alive_clr = aclr_q;
  assign smsg_clr  = sclr_q;
  assign status    = pack_status(mmsg_q, smsg, alive, hold, rd_dir, rst_q);
  assign s2m_rdata = s2m_ok ? slv_byte : FLOAT_BYTE;

  // R9
  no_release_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_q) |-> !rel_q);
  // R9
  mmsg_cleared_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> !mmsg_q);
  // R7
  m2s_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rel_q && !rst_q) |-> $stable(m2s_q));
  // R6
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |-> $past(dat_rd || dat_wr));
endmodule

// File: rtl/mslv_host_port.sv
module mslv_host_port
  import mslv_pkg::*;
#(
  parameter int NSLV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        base_jmp_n,
  input  logic [7:0]        io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [NSLV-1:0]   slv_hold,
  input  logic [NSLV-1:0]   slv_rd_dir,
  input  logic [NSLV-1:0]   slv_alive,
  input  logic [NSLV-1:0]   slv_smsg,
  input  logic [NSLV-1:0]   slv_mmsg_ack,
  input  logic [8*NSLV-1:0] slv_wdata,
  output logic [NSLV-1:0]   slv_reset,
  output logic [NSLV-1:0]   slv_mmsg,
  output logic [NSLV-1:0]   slv_release,
  output logic [8*NSLV-1:0] m2s_data,
  output logic [NSLV-1:0]   alive_clr,
  output logic [NSLV-1:0]   smsg_clr
);
  logic            hit;
  logic [NSLV-1:0] ctl_rd, ctl_wr, dat_rd, dat_wr, flg_rd, flg_wr;
  logic [7:0]      status [NSLV];
  logic [7:0]      s2m    [NSLV];

  mslv_addr_dec #(.NSLV(NSLV)) u_dec (
    .base_jmp_n(base_jmp_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .hit(hit), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .dat_rd(dat_rd),
    .dat_wr(dat_wr), .flg_rd(flg_rd), .flg_wr(flg_wr)
  );

  for (genvar g = 0; g < NSLV; g++) begin : g_slot
    mslv_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr[g]), .dat_rd(dat_rd[g]), .dat_wr(dat_wr[g]),
      .flg_rd(flg_rd[g]), .flg_wr(flg_wr[g]), .wdata(io_wdata),
      .hold(slv_hold[g]), .rd_dir(slv_rd_dir[g]), .alive(slv_alive[g]),
      .smsg(slv_smsg[g]), .mmsg_ack(slv_mmsg_ack[g]),
      .slv_byte(slv_wdata[8*g +: 8]),
      .slv_reset(slv_reset[g]), .mmsg(slv_mmsg[g]), .release_o(slv_release[g]),
      .m2s_data(m2s_data[8*g +: 8]), .alive_clr(alive_clr[g]),
      .smsg_clr(smsg_clr[g]), .status(status[g]), .s2m_rdata(s2m[g])
    );
  end

  always_comb begin
    io_rdata = FLOAT_BYTE;
    for (int i = 0; i < NSLV; i++) begin
      if (ctl_rd[i]) io_rdata = status[i];
      if (dat_rd[i]) io_rdata = s2m[i];
    end
  end

  // R1
  float_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd || !hit) |-> io_rdata == FLOAT_BYTE);
  // R10
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_rd | ctl_wr | dat_rd | dat_wr | flg_rd | flg_wr));
endmodule

// File: tb/mslv_host_port_tb.sv
module mslv_host_port_tb;
  localparam int NSLV = 3;

  logic clk = 0, rst_n = 0;
  logic [3:0] base_jmp_n = 4'b0110;
  logic [7:0] io_addr = 0, io_wdata = 0, io_rdata;
  logic io_rd = 0, io_wr = 0;
  logic [NSLV-1:0] slv_hold = 0, slv_rd_dir = 0, slv_alive = 0, slv_smsg = 0, slv_mmsg_ack = 0;
  logic [8*NSLV-1:0] slv_wdata = {8'h5A, 8'h3C, 8'hA5};
  logic [NSLV-1:0] slv_reset, slv_mmsg, slv_release, alive_clr, smsg_clr;
  logic [8*NSLV-1:0] m2s_data;

  int nvec = 0, nbad = 0;
  logic [NSLV-1:0] m_rst, m_mmsg;
  logic [7:0] base;

  always #10 clk = ~clk;

  mslv_host_port #(.NSLV(NSLV)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] code, input logic [7:0] a);
    logic [1:0] s, p;
    s = a[3:2]; p = a[1:0];
    if (a[7:4] != ~code || s == 2'd3 || p == 2'd3 || p == 2'd2) return 8'hFF;
    if (p == 2'd0)
      return {2'b11, ~m_rst[s], slv_rd_dir[s], ~(slv_hold[s] & ~m_rst[s]),
              ~(slv_alive[s] & ~m_rst[s]), slv_smsg[s] & ~m_rst[s], m_mmsg[s]};
    if (!m_rst[s] && slv_hold[s] && !slv_rd_dir[s]) return slv_wdata[8*s +: 8];
    return 8'hFF;
  endfunction

  task automatic sweep(input string req);
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 256; a++) begin
        @(negedge clk);
        base_jmp_n = 4'(c); io_addr = 8'(a); io_rd = 1;
        #2 chk(req, io_rdata, exp_rd(4'(c), 8'(a)));
      end
    end
    @(negedge clk); io_rd = 0; base_jmp_n = 4'b0110;
    #2 chk("R1 idle", io_rdata, 8'hFF);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  initial begin
    #(200000 * 20);
    nbad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    base = 8'h90;
    m_rst = '1; m_mmsg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4 / R9 reset state
    chk("R4 reset", slv_reset, 3'b111);
    chk("R4 mmsg", slv_mmsg, 3'b000);
    chk("R4 m2s", m2s_data, 24'h0);
    chk("R9 clr", {alive_clr, smsg_clr}, 6'b111111);
    chk("R9 rel", slv_release, 3'b000);

    slv_hold = 3'b101; slv_rd_dir = 3'b001; slv_alive = 3'b011; slv_smsg = 3'b110;
    sweep("R1 R2 R9 sweep held");

    // R3 R10 independent release
    wr(base + 8'h0, 8'h00); m_rst[0] = 0;
    chk("R3 R10 rel0", slv_reset, 3'b110);
    wr(base + 8'h4, 8'h00); m_rst[1] = 0;
    chk("R3 R10 rel1", slv_reset, 3'b100);
    wr(base + 8'h8, 8'h00); m_rst[2] = 0;
    chk("R3 R10 rel2", slv_reset, 3'b000);
    chk("R9 clr low", {alive_clr, smsg_clr}, 6'b0);
    sweep("R1 R2 sweep run A");
    slv_hold = 3'b010; slv_rd_dir = 3'b000; slv_alive = 3'b101; slv_smsg = 3'b001;
    sweep("R1 R2 sweep run B");

    // R3 master message
    wr(base + 8'h4, 8'h02); m_mmsg[1] = 1;
    chk("R3 mmsg set", slv_mmsg, 3'b010);
    wr(base + 8'h4, 8'hED);
    chk("R3 other bits", {slv_mmsg, slv_reset}, {3'b010, 3'b000});
    // R5 ack
    @(negedge clk); slv_mmsg_ack = 3'b010;
    @(negedge clk); slv_mmsg_ack = 0; m_mmsg[1] = 0;
    chk("R5 ack", slv_mmsg, 3'b000);
    // R5 set beats ack
    @(negedge clk); io_addr = base + 8'h4; io_wdata = 8'h02; io_wr = 1; slv_mmsg_ack = 3'b010;
    @(negedge clk); io_wr = 0; slv_mmsg_ack = 0;
    chk("R5 set wins", slv_mmsg, 3'b010);

    // R6 stalled write read
    slv_hold = 3'b100; slv_rd_dir = 3'b000;
    @(negedge clk); io_addr = base + 8'h9; io_rd = 1;
    #2 chk("R6 byte", io_rdata, 8'h5A);
    @(negedge clk); io_rd = 0;
    chk("R6 release", slv_release, 3'b100);
    @(negedge clk);
    chk("R6 one pulse", slv_release, 3'b000);
    @(negedge clk); io_addr = base + 8'h1; io_rd = 1;
    #2 chk("R6 not stalled", io_rdata, 8'hFF);
    @(negedge clk); io_rd = 0;
    chk("R6 no release", slv_release, 3'b000);

    // R7 stalled read write
    slv_hold = 3'b011; slv_rd_dir = 3'b001;
    wr(base + 8'h1, 8'h77);
    chk("R7 latch", m2s_data, 24'h000077);
    chk("R7 release", slv_release, 3'b001);
    wr(base + 8'h5, 8'h11);
    chk("R7 wrong dir", {m2s_data, slv_release}, {24'h000077, 3'b000});

    // R8 flag port
    @(negedge clk); io_addr = base + 8'h2; io_rd = 1;
    @(negedge clk); io_rd = 0;
    chk("R8 alive clr", {alive_clr, smsg_clr}, {3'b001, 3'b000});
    wr(base + 8'h6, 8'h00);
    chk("R8 smsg clr", {alive_clr, smsg_clr}, {3'b000, 3'b010});

    // R1 out-of-window writes carry a reset+message code
    for (int a = 0; a < 256; a++) begin
      if (!(a[7:4] == 4'h9 && a[3:2] != 2'd3 && a[1:0] != 2'd3)) wr(8'(a), 8'h12);
    end
    chk("R1 ignored wr", {slv_reset, slv_mmsg, m2s_data}, {3'b000, 3'b010, 24'h000077});

    // R9 reset beats message, clears pending byte
    wr(base + 8'h0, 8'h02);
    chk("R3 mmsg0", slv_mmsg, 3'b011);
    wr(base + 8'h0, 8'h12);
    chk("R9 reset", {slv_reset, slv_mmsg}, {3'b001, 3'b010});
    chk("R9 m2s", m2s_data, 24'h0);
    chk("R9 clr held", {alive_clr, smsg_clr}, {3'b001, 3'b001});
    wr(base + 8'h1, 8'h44);
    chk("R9 no rel", {m2s_data, slv_release}, {24'h0, 3'b000});

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule